// File: doc/BRIEF.md
# Critical-Word-First Line Fill Buffer

This block services a cache read miss by collecting a full cache line from a memory bus that is narrower than the line. It accepts a miss made of a line address and the index of the chunk that holds the wanted data. It then issues one wrapping burst request that starts at that chunk. Returning beats are placed into a separate line buffer. The first beat is the one the core is waiting for, and it is handed to the core on its own as soon as it has been captured, so the core can restart while the other chunks are still arriving.

After the wanted chunk, the chunk index steps upward and wraps modulo the number of chunks per line. A per-chunk valid mask records which chunks have landed. Once every chunk is present, the block drives the whole line, with its line address, to the cache data array for exactly one cycle. Then it returns to idle. With the default sizes, a line is 32 bytes and a beat is 8 bytes, so a fill takes four beats. A miss on byte 0x95 of the line at 0x80 fetches chunks 0x90, 0x98, 0x80, 0x88 in that order.

Top module: `cwf_fill_buffer`

## Requirements
- R1: After reset, `miss_ready` is 1, and `mem_req_valid`, `core_data_valid`, `fill_we` and `fill_mask` are all 0.
- R2: A miss is accepted only when `miss_ready` is high, which happens only in idle. From the cycle after acceptance until the fill completes, `miss_ready` is 0 and `miss_valid` has no effect: the line written is the one first accepted.
- R3: In the cycle after acceptance, `mem_req_valid` is 1 and `mem_req_addr` equals `{miss_line, miss_word, 3'b000}`, which is the byte address of the wanted chunk. Both stay unchanged until the cycle `mem_req_ready` is seen high, and `mem_req_valid` is 0 afterwards.
- R4: Beat k of the burst (k = 0, 1, 2, 3) is stored as chunk (miss_word + k) mod 4 of the line.
- R5: In the cycle after the first beat is captured, `core_data_valid` is 1 for exactly one cycle, with `core_data` equal to that first beat. It stays 0 for all other beats.
- R6: Bit i of `fill_mask` becomes 1 in the cycle after chunk i is captured. It is unchanged in cycles with no beat.
- R7: In the cycle after the last beat is captured, `fill_we` is 1 for exactly one cycle, with `fill_mask` equal to 4'b1111. During that cycle, `fill_addr` is `{miss_line, 5'b0}` and chunk i is held in `fill_data[64*i+63 : 64*i]`.
- R8: `mem_rsp_valid` while no fill is in progress has no effect: `fill_mask` stays 0 and `core_data_valid` stays 0.
- R9: In the cycle after `fill_we`, `miss_ready` is 1 again and `fill_mask` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Block is idle and takes a miss |
| miss_line | input | 27 | Line address (byte address bits 31:5) |
| miss_word | input | 2 | Index of the chunk holding the wanted data |
| mem_req_valid | output | 1 | Burst read request pending |
| mem_req_ready | input | 1 | Memory side takes the request |
| mem_req_addr | output | 32 | Byte address of the first (wanted) chunk |
| mem_rsp_valid | input | 1 | A response beat is present |
| mem_rsp_data | input | 64 | Response beat data |
| core_data_valid | output | 1 | One-cycle early-restart pulse |
| core_data | output | 64 | Wanted chunk for the core |
| fill_mask | output | 4 | Chunks captured so far |
| fill_we | output | 1 | One-cycle line write strobe |
| fill_addr | output | 32 | Byte address of the line being written |
| fill_data | output | 256 | Whole line, chunk i in bits 64*i+63:64*i |

## Verification
The assertions take for granted that the memory side returns exactly four beats per burst, and only after the request handshake. They also take for granted that it never sends a beat while the block is requesting or writing. The bench keeps to this: each scenario drives exactly four beats after the handshake, with optional idle gaps between them. The only stray beats it sends are sent while the block sits idle, where the block must ignore them. Requests held back by a slow `mem_req_ready` and misses offered during a fill are both applied, so the hold rules of the request and the busy rule are exercised.

// File: rtl/cwf_fill_buffer.sv
module cwf_fill_buffer #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int BEAT_BYTES = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   miss_valid,
  output logic                                   miss_ready,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   miss_line,
  input  logic [$clog2(LINE_BYTES/BEAT_BYTES)-1:0] miss_word,
  output logic                                   mem_req_valid,
  input  logic                                   mem_req_ready,
  output logic [ADDR_W-1:0]                      mem_req_addr,
  input  logic                                   mem_rsp_valid,
  input  logic [BEAT_BYTES*8-1:0]                mem_rsp_data,
  output logic                                   core_data_valid,
  output logic [BEAT_BYTES*8-1:0]                core_data,
  output logic [LINE_BYTES/BEAT_BYTES-1:0]       fill_mask,
  output logic                                   fill_we,
  output logic [ADDR_W-1:0]                      fill_addr,
  output logic [LINE_BYTES*8-1:0]                fill_data
);
  localparam int BEATS    = LINE_BYTES / BEAT_BYTES;
  localparam int IDX_W    = $clog2(BEATS);
  localparam int OFS_W    = $clog2(LINE_BYTES);
  localparam int BOFS_W   = $clog2(BEAT_BYTES);
  localparam int BEAT_W   = BEAT_BYTES * 8;
  localparam int LINE_A_W = ADDR_W - OFS_W;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_FILL, S_WRITE} state_t;

  state_t              st;
  logic [LINE_A_W-1:0] line_q;
  logic [IDX_W-1:0]    crit_q;
  logic [IDX_W-1:0]    nxt_q;
  logic [BEATS-1:0]    mask_q;
  logic                early_v;
  logic [BEAT_W-1:0]   early_d;
  logic [BEAT_W-1:0]   buf_q [BEATS];

  logic                take_beat;
  logic [BEATS-1:0]    hit_vec;
  logic [BEATS-1:0]    mask_nx;

  assign take_beat = (st == S_FILL) && mem_rsp_valid;
  assign hit_vec   = BEATS'(1) << nxt_q;
  assign mask_nx   = mask_q | hit_vec;

  assign miss_ready      = (st == S_IDLE);
  assign mem_req_valid   = (st == S_REQ);
  assign mem_req_addr    = {line_q, crit_q, {BOFS_W{1'b0}}};
  assign core_data_valid = early_v;
  assign core_data       = early_d;
  assign fill_mask       = mask_q;
  assign fill_we         = (st == S_WRITE);
  assign fill_addr       = {line_q, {OFS_W{1'b0}}};

  for (genvar i = 0; i < BEATS; i++) begin : g_line
    assign fill_data[i*BEAT_W +: BEAT_W] = buf_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      line_q  <= '0;
      crit_q  <= '0;
      nxt_q   <= '0;
      mask_q  <= '0;
      early_v <= 1'b0;
      early_d <= '0;
    end else begin
      early_v <= 1'b0;
      case (st)
        S_IDLE: if (miss_valid) begin
          line_q <= miss_line;
          crit_q <= miss_word;
          nxt_q  <= miss_word;
          mask_q <= '0;
          st     <= S_REQ;
        end
        S_REQ: if (mem_req_ready) st <= S_FILL;
        S_FILL: if (mem_rsp_valid) begin
          mask_q <= mask_nx;
          nxt_q  <= nxt_q + 1'b1;
          if (mask_q == '0) begin
            early_v <= 1'b1;
            early_d <= mem_rsp_data;
          end
          if (&mask_nx) st <= S_WRITE;
        end
        default: begin
          mask_q <= '0;
          st     <= S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take_beat) buf_q[nxt_q] <= mem_rsp_data;
  end

  AST_EARLY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    core_data_valid |=> !core_data_valid); // R5
  AST_WE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |-> (&fill_mask)); // R7
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |=> (!fill_we && miss_ready && fill_mask == '0)); // R9
  AST_MASK_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    take_beat |=> ($countones(fill_mask) == $countones($past(fill_mask)) + 1)); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!miss_ready && !fill_we) |=> $stable(fill_addr)); // R2
endmodule

// File: tb/sim_cwf_fill_buffer.sv
module sim_cwf_fill_buffer;
  localparam int PERIOD = 10;
  localparam int LW = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_valid = 1'b0;
  logic miss_ready;
  logic [LW-1:0] miss_line = '0;
  logic [1:0] miss_word = '0;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic core_data_valid;
  logic [63:0] core_data;
  logic [3:0] fill_mask;
  logic fill_we;
  logic [31:0] fill_addr;
  logic [255:0] fill_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  cwf_fill_buffer u0 (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_line(miss_line), .miss_word(miss_word),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .core_data_valid(core_data_valid), .core_data(core_data),
    .fill_mask(fill_mask), .fill_we(fill_we),
    .fill_addr(fill_addr), .fill_data(fill_data)
  );

  function automatic logic [63:0] chunk_val(input logic [LW-1:0] ln, input int j);
    return {5'd0, ln, 24'hA5C3E1, 6'd0, 2'(j)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_fill(input logic [LW-1:0] ln, input logic [1:0] wd,
                          input int req_delay, input int gap, input bit poke);
    logic [31:0] exp_addr;
    logic [3:0] emask;
    exp_addr = {ln, wd, 3'b000};
    chk(miss_ready == 1'b1, "R9 ready before miss", 256'(miss_ready), 256'(1));
    miss_valid = 1'b1; miss_line = ln; miss_word = wd;
    @(negedge clk);
    miss_valid = 1'b0;
    chk(miss_ready == 1'b0, "R2 busy after accept", 256'(miss_ready), 256'(0));
    chk(mem_req_valid && mem_req_addr == exp_addr, "R3 request address",
        256'(mem_req_addr), 256'(exp_addr));
    for (int d = 0; d < req_delay; d++) begin
      @(negedge clk);
      chk(mem_req_valid && mem_req_addr == exp_addr, "R3 request held",
          256'(mem_req_addr), 256'(exp_addr));
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk(!mem_req_valid, "R3 request dropped", 256'(mem_req_valid), 256'(0));
    if (poke) begin
      miss_valid = 1'b1; miss_line = ln ^ 27'h1; miss_word = wd + 2'd1;
    end
    emask = '0;
    for (int k = 0; k < 4; k++) begin
      int j;
      j = (int'(wd) + k) % 4;
      mem_rsp_valid = 1'b1;
      mem_rsp_data = chunk_val(ln, j);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      emask[j] = 1'b1;
      chk(fill_mask == emask, "R6 mask after beat", 256'(fill_mask), 256'(emask));
      chk(core_data_valid == (k == 0), "R5 early pulse", 256'(core_data_valid), 256'(k == 0));
      if (k == 0)
        chk(core_data == chunk_val(ln, int'(wd)), "R5 early data",
            256'(core_data), 256'(chunk_val(ln, int'(wd))));
      if (poke)
        chk(miss_ready == 1'b0, "R2 ready low during fill", 256'(miss_ready), 256'(0));
      chk(fill_we == (k == 3), "R7 strobe timing", 256'(fill_we), 256'(k == 3));
      if (k < 3) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          chk(fill_mask == emask && !core_data_valid, "R6 mask stable in gap",
              256'(fill_mask), 256'(emask));
        end
      end
    end
    miss_valid = 1'b0;
    chk(fill_addr == {ln, 5'd0}, "R7 R2 line address", 256'(fill_addr), 256'({ln, 5'd0}));
    for (int i = 0; i < 4; i++)
      chk(fill_data[i*64 +: 64] == chunk_val(ln, i), "R4 R7 chunk placement",
          256'(fill_data[i*64 +: 64]), 256'(chunk_val(ln, i)));
    @(negedge clk);
    chk(!fill_we, "R7 strobe one cycle", 256'(fill_we), 256'(0));
    chk(miss_ready && fill_mask == 4'd0, "R9 back to idle",
        256'({miss_ready, fill_mask}), 256'({1'b1, 4'd0}));
    chk(!mem_req_valid, "R2 offered miss not taken", 256'(mem_req_valid), 256'(0));
  endtask

  task automatic stray_beats();
    for (int i = 0; i < 3; i++) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data = 64'hDEAD_BEEF_0000_0000 | 64'(i);
      @(negedge clk);
      chk(fill_mask == 4'd0 && !core_data_valid && !fill_we, "R8 stray beat ignored",
          256'({fill_mask, core_data_valid, fill_we}), 256'(0));
    end
    mem_rsp_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(miss_ready && !mem_req_valid && !core_data_valid && !fill_we && fill_mask == 4'd0,
        "R1 reset state in reset",
        256'({miss_ready, mem_req_valid, core_data_valid, fill_we, fill_mask}), 256'({1'b1, 7'd0}));
    rst_n = 1'b1;
    @(negedge clk);
    chk(miss_ready && !mem_req_valid && fill_mask == 4'd0, "R1 reset state after release",
        256'({miss_ready, mem_req_valid, fill_mask}), 256'({1'b1, 5'd0}));
    stray_beats();
    run_fill(27'h4, 2'd2, 0, 0, 1'b0);
    run_fill(27'h1234, 2'd0, 2, 0, 1'b0);
    run_fill(27'h7FF_FFFF, 2'd3, 1, 2, 1'b1);
    run_fill(27'h0ABCD, 2'd1, 3, 1, 1'b1);
    stray_beats();
    run_fill(27'h5, 2'd2, 0, 0, 1'b1);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule